// File: doc/BRIEF.md
# Interleaved Burst Channel Tagger

This block sits on the receive side of a burst-based packet interface whose data bus holds eight words. Packets for many channels arrive split into bursts, and bursts of different channels may be interleaved on the bus. The channel number is only meaningful on the beat that opens a burst. The tagger captures it there and attaches it to every beat of that burst. It also keeps an open/closed packet bit for every channel, so that a packet can resume in a later burst after bursts of other channels have passed.

Each accepted beat leaves one cycle later and carries the following: its channel tag, an eight-bit valid-word mask expanded from the word count, the data with its invalid words forced to zero, the framing flags, and a six-bit error vector. The error vector flags framing violations of the burst and packet rules.

Both sides use valid/ready. An input beat is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds all its values and the input is stalled. Only single-segment operation is supported, in which the upper start-of-burst bit marks a burst start and the lower bit must stay low.

Top module: `ilkt_burst_tagger`

## Requirements
- R1: While `out_valid` is high and `out_ready` is low, every output holds its value and `in_ready` is low. Otherwise `in_ready` is high.
- R2: A beat taken on an edge appears on the outputs after that edge, and its flags are copied to `out_sop`, `out_sob`, `out_eob` and `out_eop`. A cycle that takes no beat changes no state. When `out_ready` is high and no beat is taken, `out_valid` goes low.
- R3: A beat with `in_sob[1]` high is tagged with `in_chan` and loads it as the burst channel. Every other beat is tagged with the loaded burst channel, whatever `in_chan` carries.
- R4: `out_mask` has its n most significant bits set for a count n from 0 to 8. Bit 7 stands for the most significant word. A count above 8 gives all ones.
- R5: Word k of the data is bits [16k+15:16k], and word 7 is the top word. Output words whose mask bit is clear are zero, and the other words pass unchanged.
- R6: A burst opens on a beat with `in_sob[1]` high. It closes on a beat with `in_eob` or `in_eop` high, and this also applies to a beat that both opens and closes the burst.
- R7: Each of the 256 channels has its own packet-open bit. On any beat except an `out_err[0]` beat, the bit of the tagged channel is cleared by `in_eop`; otherwise it is set by `in_sop`. These bits persist across interleaved bursts of other channels.
- R8: `out_err[0]` is set for a beat with `in_sob[1]` low while no burst is open. Such a beat does not touch any packet bit.
- R9: `out_err[1]` is set for a beat with `in_sob[1]` high while a burst is already open. The new burst then replaces the old one.
- R10: `out_err[2]` is set for a beat with `in_sop` high when the packet of the tagged channel is already open or when `in_sob[1]` is low.
- R11: `out_err[3]` is set for a beat with `in_sob[1]` high and `in_sop` low when the packet of that channel is closed.
- R12: `out_err[4]` is set when `in_sob[0]` is high, and `out_err[5]` is set when `in_count` is above 8.
- R13: A synchronous active-high `rst` empties the output, closes the burst, zeroes the burst channel and closes the packet bits of all channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat can be taken |
| in_sop | input | 1 | Beat starts a packet |
| in_sob | input | 2 | Start of burst; bit 1 is used, bit 0 must stay low |
| in_eob | input | 1 | Beat ends the burst |
| in_eop | input | 1 | Beat ends the packet |
| in_count | input | 4 | Number of valid words, packed at the top |
| in_chan | input | 8 | Channel, meaningful only with `in_sob[1]` |
| in_data | input | 128 | Eight 16-bit words, word 7 on top |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream takes the output beat |
| out_sop | output | 1 | Copied start-of-packet flag |
| out_sob | output | 1 | Copied start-of-burst flag |
| out_eob | output | 1 | Copied end-of-burst flag |
| out_eop | output | 1 | Copied end-of-packet flag |
| out_chan | output | 8 | Channel tag of the beat |
| out_mask | output | 8 | Valid-word mask, bit 7 for the top word |
| out_data | output | 128 | Data with invalid words zeroed |
| out_err | output | 6 | Framing error flags |

## Verification
A wrong burst-channel register shows up at the ports on the very next middle-of-burst beat, as a wrong `out_chan` one cycle after that beat is taken. A wrong burst-open bit shows up one cycle after the next beat, as a spurious or missing `out_err[0]` or `out_err[1]`. A corrupted packet-open bit stays hidden until that channel next starts a burst. That can be many cycles later, behind bursts of other channels, and it then appears as a wrong `out_err[2]` or `out_err[3]`. The bench therefore interleaves a handful of channels and reopens each one often, so that such faults come to light within a few bursts.

// File: rtl/ilkt_pkg.sv
package ilkt_pkg;
  localparam int ERR_W       = 6;
  localparam int ERR_NOBURST = 0;
  localparam int ERR_REOPEN  = 1;
  localparam int ERR_SOP     = 2;
  localparam int ERR_NOSOP   = 3;
  localparam int ERR_LOSOB   = 4;
  localparam int ERR_COUNT   = 5;

  typedef struct packed {
    logic sop;
    logic sob;
    logic eob;
    logic eop;
  } ilkt_flags_t;
endpackage

// File: rtl/ilkt_mask_gen.sv
module ilkt_mask_gen #(
  parameter int WORDS = 8,
  parameter int CNT_W = 4
) (
  input  logic [CNT_W-1:0] cnt,
  output logic [WORDS-1:0] mask,
  output logic             over
);
  // Bit i is valid when at least WORDS-i words are present (top-packed).
  for (genvar i = 0; i < WORDS; i++) begin : g_bit
    assign mask[i] = (32'(cnt) >= 32'(WORDS - i));
  end
  assign over = (32'(cnt) > 32'(WORDS));
endmodule

// File: rtl/ilkt_chan_track.sv
module ilkt_chan_track
  import ilkt_pkg::*;
#(
  parameter int CHAN_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc,
  input  ilkt_flags_t       flg,
  input  logic              sob_lo,
  input  logic              cnt_over,
  input  logic [CHAN_W-1:0] chan,
  output logic [CHAN_W-1:0] tag_chan,
  output logic [ERR_W-1:0]  err
);
  localparam int NCHAN = 1 << CHAN_W;

  logic              burst_open;
  logic [CHAN_W-1:0] burst_chan;
  logic [NCHAN-1:0]  pkt_open;
  logic              pkt_bit;
  logic              burst_end;

  assign tag_chan  = flg.sob ? chan : burst_chan;
  assign pkt_bit   = pkt_open[tag_chan];
  assign burst_end = flg.eob | flg.eop;

  always_comb begin
    err                = '0;
    err[ERR_NOBURST]   = !flg.sob && !burst_open;
    err[ERR_REOPEN]    = flg.sob && burst_open;
    err[ERR_SOP]       = flg.sop && (pkt_bit || !flg.sob);
    err[ERR_NOSOP]     = flg.sob && !flg.sop && !pkt_bit;
    err[ERR_LOSOB]     = sob_lo;
    err[ERR_COUNT]     = cnt_over;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      burst_open <= 1'b0;
      burst_chan <= '0;
    end else if (acc) begin
      if (flg.sob) burst_chan <= chan;
      if (burst_end)    burst_open <= 1'b0;
      else if (flg.sob) burst_open <= 1'b1;
    end
  end

  for (genvar c = 0; c < NCHAN; c++) begin : g_pkt
    always_ff @(posedge clk) begin
      if (rst) begin
        pkt_open[c] <= 1'b0;
      end else if (acc && !err[ERR_NOBURST] && (tag_chan == CHAN_W'(c))) begin
        if (flg.eop)      pkt_open[c] <= 1'b0;
        else if (flg.sop) pkt_open[c] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ilkt_out_stage.sv
module ilkt_out_stage #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [PW-1:0] s_pay,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [PW-1:0] m_pay
);
  assign s_ready = !m_valid || m_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_pay   <= '0;
    end else if (s_ready) begin
      m_valid <= s_valid;
      if (s_valid) m_pay <= s_pay;
    end
  end
endmodule

// File: rtl/ilkt_burst_tagger.sv
module ilkt_burst_tagger
  import ilkt_pkg::*;
#(
  parameter int WORDS  = 8,
  parameter int WORD_W = 16,
  parameter int CNT_W  = 4,
  parameter int CHAN_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_sop,
  input  logic [1:0]              in_sob,
  input  logic                    in_eob,
  input  logic                    in_eop,
  input  logic [CNT_W-1:0]        in_count,
  input  logic [CHAN_W-1:0]       in_chan,
  input  logic [WORDS*WORD_W-1:0] in_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic                    out_sop,
  output logic                    out_sob,
  output logic                    out_eob,
  output logic                    out_eop,
  output logic [CHAN_W-1:0]       out_chan,
  output logic [WORDS-1:0]        out_mask,
  output logic [WORDS*WORD_W-1:0] out_data,
  output logic [ERR_W-1:0]        out_err
);
  localparam int DW = WORDS * WORD_W;
  localparam int PW = DW + WORDS + CHAN_W + ERR_W + 4;

  ilkt_flags_t       flg;
  ilkt_flags_t       oflg;
  logic [WORDS-1:0]  mask;
  logic              over;
  logic [CHAN_W-1:0] tag_chan;
  logic [ERR_W-1:0]  err;
  logic [DW-1:0]     data_z;
  logic [PW-1:0]     pay_in;
  logic [PW-1:0]     pay_out;
  logic              acc;

  assign flg.sop = in_sop;
  assign flg.sob = in_sob[1];
  assign flg.eob = in_eob;
  assign flg.eop = in_eop;
  assign acc     = in_valid && in_ready;

  ilkt_mask_gen #(.WORDS(WORDS), .CNT_W(CNT_W)) u_mask (
    .cnt  (in_count),
    .mask (mask),
    .over (over)
  );

  ilkt_chan_track #(.CHAN_W(CHAN_W)) u_track (
    .clk      (clk),
    .rst      (rst),
    .acc      (acc),
    .flg      (flg),
    .sob_lo   (in_sob[0]),
    .cnt_over (over),
    .chan     (in_chan),
    .tag_chan (tag_chan),
    .err      (err)
  );

  for (genvar k = 0; k < WORDS; k++) begin : g_word
    assign data_z[k*WORD_W +: WORD_W] = mask[k] ? in_data[k*WORD_W +: WORD_W] : '0;
  end

  assign pay_in = {data_z, mask, tag_chan, err, flg};

  ilkt_out_stage #(.PW(PW)) u_out (
    .clk     (clk),
    .rst     (rst),
    .s_valid (in_valid),
    .s_ready (in_ready),
    .s_pay   (pay_in),
    .m_valid (out_valid),
    .m_ready (out_ready),
    .m_pay   (pay_out)
  );

  assign {out_data, out_mask, out_chan, out_err, oflg} = pay_out;
  assign out_sop = oflg.sop;
  assign out_sob = oflg.sob;
  assign out_eob = oflg.eob;
  assign out_eop = oflg.eop;
endmodule

// File: rtl/ilkt_burst_tagger_chk.sv
module ilkt_burst_tagger_chk #(
  parameter int WORDS  = 8,
  parameter int WORD_W = 16,
  parameter int CHAN_W = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic [1:0]              in_sob,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic                    out_sob,
  input logic [CHAN_W-1:0]       out_chan,
  input logic [WORDS-1:0]        out_mask,
  input logic [WORDS*WORD_W-1:0] out_data,
  input logic [5:0]              out_err
);
  logic [WORDS*WORD_W-1:0] keep;
  logic [CHAN_W-1:0]       last_chan;
  logic                    seen;

  for (genvar k = 0; k < WORDS; k++) begin : g_keep
    assign keep[k*WORD_W +: WORD_W] = {WORD_W{out_mask[k]}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen      <= 1'b0;
      last_chan <= '0;
    end else if (out_valid && out_ready) begin
      seen      <= 1'b1;
      last_chan <= out_chan;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_chan) && $stable(out_data) && $stable(out_err)); // R1
  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready); // R1
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid); // R2
  AST_DRAIN: assert property (@(posedge clk) disable iff (rst)
    out_ready && !(in_valid && in_ready) |=> !out_valid); // R2
  AST_CHAN_HELD: assert property (@(posedge clk) disable iff (rst)
    out_valid && seen && !out_sob && !out_err[0] |-> out_chan == last_chan); // R3
  AST_MASK_TOP: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((~out_mask) & ((~out_mask) + 1'b1)) == '0); // R4
  AST_ZERO_PAD: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_data & ~keep) == '0); // R5
  AST_LOSOB_FLAG: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_sob[0] |=> out_err[4]); // R12
endmodule

bind ilkt_burst_tagger ilkt_burst_tagger_chk #(
  .WORDS(WORDS), .WORD_W(WORD_W), .CHAN_W(CHAN_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_sob(in_sob),
  .out_valid(out_valid), .out_ready(out_ready), .out_sob(out_sob), .out_chan(out_chan),
  .out_mask(out_mask), .out_data(out_data), .out_err(out_err)
);

// File: tb/ilkt_burst_tagger_tb_top.sv
module ilkt_burst_tagger_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic         in_sop = 1'b0;
  logic [1:0]   in_sob = 2'b00;
  logic         in_eob = 1'b0;
  logic         in_eop = 1'b0;
  logic [3:0]   in_count = 4'd0;
  logic [7:0]   in_chan = 8'd0;
  logic [127:0] in_data = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic         out_sop, out_sob, out_eob, out_eop;
  logic [7:0]   out_chan;
  logic [7:0]   out_mask;
  logic [127:0] out_data;
  logic [5:0]   out_err;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // reference model state
  bit     m_popen [256];
  bit     m_bopen;
  int     m_bchan;
  bit     e_valid;
  bit     e_sop, e_sob, e_eob, e_eop;
  int     e_chan;
  bit [7:0]   e_mask;
  bit [127:0] e_data;
  bit [5:0]   e_err;

  always #5 clk = ~clk;

  ilkt_burst_tagger dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_sop(in_sop),
    .in_sob(in_sob), .in_eob(in_eob), .in_eop(in_eop), .in_count(in_count),
    .in_chan(in_chan), .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_sop(out_sop), .out_sob(out_sob), .out_eob(out_eob), .out_eop(out_eop),
    .out_chan(out_chan), .out_mask(out_mask), .out_data(out_data), .out_err(out_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    foreach (m_popen[i]) m_popen[i] = 1'b0;
    m_bopen = 1'b0;
    m_bchan = 0;
    e_valid = 1'b0;
  endtask

  task automatic compare_out(input string tag);
    chk(out_valid == e_valid, "R2", {tag, " out_valid"}, 128'(out_valid), 128'(e_valid));
    if (e_valid && out_valid) begin
      chk({out_sop, out_sob, out_eob, out_eop} == {e_sop, e_sob, e_eob, e_eop}, "R2",
          {tag, " flags"}, 128'({out_sop, out_sob, out_eob, out_eop}), 128'({e_sop, e_sob, e_eob, e_eop}));
      chk(out_chan == 8'(e_chan), "R3", {tag, " chan"}, 128'(out_chan), 128'(e_chan));
      chk(out_mask == e_mask, "R4", {tag, " mask"}, 128'(out_mask), 128'(e_mask));
      chk(out_data == e_data, "R5", {tag, " data"}, out_data, e_data);
      chk(out_err[0] == e_err[0], "R8", {tag, " err0"}, 128'(out_err), 128'(e_err));
      chk(out_err[1] == e_err[1], "R9", {tag, " err1"}, 128'(out_err), 128'(e_err));
      chk(out_err[2] == e_err[2], "R10", {tag, " err2"}, 128'(out_err), 128'(e_err));
      chk(out_err[3] == e_err[3], "R11", {tag, " err3"}, 128'(out_err), 128'(e_err));
      chk(out_err[5:4] == e_err[5:4], "R12", {tag, " err5:4"}, 128'(out_err), 128'(e_err));
    end
  endtask

  // One clock: check outputs, drive a beat, and advance the model.
  task automatic cyc(input bit v, input bit sop, input bit s1, input bit s0,
                     input bit eob, input bit eop, input int cnt, input int ch,
                     input bit rdy, input string tag);
    bit exp_rdy;
    bit [127:0] d;
    int ce;
    bit po;
    @(negedge clk);
    compare_out(tag);
    d = {$urandom, $urandom, $urandom, $urandom};
    out_ready = rdy;
    in_valid = v; in_sop = sop; in_sob = {s1, s0}; in_eob = eob; in_eop = eop;
    in_count = 4'(cnt); in_chan = 8'(ch); in_data = d;
    #1;
    exp_rdy = !e_valid || rdy;
    chk(in_ready == exp_rdy, "R1", {tag, " in_ready"}, 128'(in_ready), 128'(exp_rdy));
    if (exp_rdy) begin
      e_valid = v;
      if (v) begin
        ce = s1 ? ch : m_bchan;
        po = m_popen[ce];
        e_err = '0;
        e_err[0] = !s1 && !m_bopen;
        e_err[1] = s1 && m_bopen;
        e_err[2] = sop && (po || !s1);
        e_err[3] = s1 && !sop && !po;
        e_err[4] = s0;
        e_err[5] = cnt > 8;
        e_mask = '0;
        for (int k = 0; k < cnt && k < 8; k++) e_mask[7-k] = 1'b1;
        e_data = '0;
        for (int w = 0; w < 8; w++) if (e_mask[w]) e_data[w*16 +: 16] = d[w*16 +: 16];
        e_chan = ce;
        {e_sop, e_sob, e_eob, e_eop} = {sop, s1, eob, eop};
        if (!e_err[0]) begin
          if (eop) m_popen[ce] = 1'b0;
          else if (sop) m_popen[ce] = 1'b1;
        end
        if (s1) m_bchan = ch;
        if (eob || eop) m_bopen = 1'b0;
        else if (s1) m_bopen = 1'b1;
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_clear();
    #1;
    chk(out_valid == 1'b0, "R13", "reset out_valid", 128'(out_valid), 128'(0));
    chk(in_ready == 1'b1, "R13", "reset in_ready", 128'(in_ready), 128'(1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_clear();
    do_reset();
    // R3 R4: single packet in one burst, mid beats carry a wrong channel value
    cyc(1, 1, 1, 0, 0, 0, 8, 2, 1, "R3 start");
    cyc(1, 0, 0, 0, 0, 0, 8, 99, 1, "R3 mid");
    cyc(1, 0, 0, 0, 1, 0, 8, 7, 1, "R3 eob");
    // R7 interleave: channel 4 short burst, then channel 2 resumes and ends
    cyc(1, 1, 1, 0, 1, 0, 3, 4, 1, "R7 short");
    cyc(1, 0, 1, 0, 1, 1, 1, 2, 1, "R7 resume2");
    cyc(1, 0, 1, 0, 0, 0, 0, 4, 1, "R7 resume4");
    cyc(1, 0, 0, 0, 1, 1, 5, 0, 1, "R7 end4");
    // R6: eop without eob closes the burst; the next beat is outside a burst
    cyc(1, 1, 1, 0, 0, 1, 2, 9, 1, "R6 eop close");
    cyc(1, 0, 0, 0, 0, 0, 4, 9, 1, "R8 no burst");
    // R9 R10 R11 R12 error beats
    cyc(1, 0, 1, 0, 0, 0, 6, 10, 1, "R11 no sop");
    cyc(1, 1, 1, 0, 0, 0, 7, 11, 1, "R9 reopen");
    cyc(1, 1, 0, 0, 0, 0, 8, 0, 1, "R10 mid sop");
    cyc(1, 1, 1, 1, 1, 0, 12, 11, 1, "R12 lo sob over");
    // R1: stall with a held output, then drain (R2 idle)
    cyc(1, 1, 1, 0, 1, 1, 8, 20, 0, "R1 fill");
    cyc(1, 1, 1, 0, 1, 1, 8, 21, 0, "R1 stall a");
    cyc(1, 1, 1, 0, 1, 1, 8, 22, 0, "R1 stall b");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, "R2 drain");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, "R2 idle");
    // R13: reset mid-packet closes burst and packet state
    cyc(1, 1, 1, 0, 0, 0, 8, 30, 1, "R13 open");
    do_reset();
    cyc(1, 0, 0, 0, 0, 0, 8, 30, 1, "R13 burst closed");
    cyc(1, 0, 1, 0, 1, 0, 8, 30, 1, "R13 packet closed");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, "R13 flush");
    // mixed traffic on a few channels with back-pressure
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 99);
      int chs = $urandom_range(0, 4);
      cyc($urandom_range(0, 9) < 8, $urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0,
          $urandom_range(0, 49) == 0, $urandom_range(0, 2) == 0, $urandom_range(0, 4) == 0,
          (r < 5) ? $urandom_range(9, 15) : $urandom_range(0, 8),
          (chs == 4) ? 255 : chs, $urandom_range(0, 3) != 0, "mix");
    end
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, "end");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, "end");
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule